// File: doc/BRIEF.md
# Conditioned Input Bank with Change Interrupt

This block sits between a bank of raw input pins and a register interface. Each port can either pass its pin through a single register stage or filter it with a slow periodic sampler. The sampler accepts a new level only when two consecutive samples agree, so a glitch or bounce shorter than one sampling interval never reaches the conditioned value. The sampling interval comes from an external strobe `tick_i`. In the intended system that strobe arrives about once every 31 ms from a shared slow oscillator.

Every change of a conditioned value raises a sticky change flag. A change on a port whose change-enable bit is set also marks that port as pending. The OR of the pending ports drives an interrupt status flag and an active-low interrupt pin. A read strobe from the register interface stands for a read of the input or configuration register. It clears the change flag and all pending ports. A new change that lands on the same edge as the read is kept.

Top module: `dti_input_cond`

## Requirements
- R1: On synchronous reset, `cond_o` is all zero, `trn_flag_o` and `irq_flag_o` are 0, and `int_n_o` is 1. The internal sample of every debounced port is also 0.
- R2: For a port whose `deb_en_i` bit is 0, the matching `cond_o` bit takes the pin level present at a clock edge, and shows it from that edge onward.
- R3: For a port whose `deb_en_i` bit is 1, `cond_o` changes only at an edge where `tick_i` is 1. It changes there only if the pin equals the level sampled at the previous tick edge. Every tick edge stores the current pin level as the new sample.
- R4: On a debounced port, a pin pulse that is not seen at two consecutive ticks leaves `cond_o` unchanged. This covers a pulse seen at no tick and a pulse seen at exactly one tick.
- R5: Any change of any `cond_o` bit sets `trn_flag_o` at the same edge. The flag stays set until it is cleared by a read.
- R6: A change of a `cond_o` bit whose `trn_en_i` bit is 1 sets `irq_flag_o` at the same edge. A change on a port with `trn_en_i` 0 leaves `irq_flag_o` at 0 and `int_n_o` at 1.
- R7: `int_n_o` is active low and always equals the inverse of `irq_flag_o`.
- R8: An edge with `rd_strobe_i` 1 clears `trn_flag_o` and `irq_flag_o`, and releases `int_n_o`. A change detected at that same edge sets the flags again.
- R9: Change detection uses the conditioned value. A raw pin movement on a debounced port that is not confirmed by two ticks sets neither flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | NPORTS | Raw pin levels |
| deb_en_i | input | NPORTS | Per-port debounce enable |
| trn_en_i | input | NPORTS | Per-port change-interrupt enable |
| tick_i | input | 1 | One-cycle sampling strobe from the slow oscillator |
| rd_strobe_i | input | 1 | Register read strobe; clears flags |
| cond_o | output | NPORTS | Conditioned input values |
| trn_flag_o | output | 1 | Sticky change flag, any port |
| irq_flag_o | output | 1 | Interrupt status, enabled ports only |
| int_n_o | output | 1 | Active-low interrupt pin |

## Verification
The bench aims at the debounce edge cases. It drives a pin that moves between ticks, and a pin whose first tick sample disagrees and whose second agrees. A filter that trusted one sample would let that glitch through. A filter that ignored `tick_i` would follow the raw pin. The bench also changes a port with its change-enable bit off. A design that gated the wrong flag would raise the interrupt or lose the change flag. Finally, the bench issues a read on the same edge as a new change. A clear that beat the set would drop that event.

// File: rtl/dti_pkg.sv
package dti_pkg;
  typedef struct packed {
    logic trn;
    logic irq;
  } dti_flags_t;
endpackage

// File: rtl/dti_debounce.sv
module dti_debounce (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  input  logic deb_en_i,
  input  logic tick_i,
  output logic cond_d_o,
  output logic cond_q_o
);
  logic samp_q;

  // Next conditioned value: either the raw pin, or the pin once two ticks agree.
  always_comb begin
    cond_d_o = cond_q_o;
    if (!deb_en_i)
      cond_d_o = pin_i;
    else if (tick_i && (pin_i == samp_q))
      cond_d_o = pin_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      samp_q   <= 1'b0;
      cond_q_o <= 1'b0;
    end else begin
      cond_q_o <= cond_d_o;
      if (tick_i) samp_q <= pin_i;
    end
  end
endmodule

// File: rtl/dti_event_merge.sv
module dti_event_merge
  import dti_pkg::*;
#(
  parameter int NPORTS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NPORTS-1:0] cond_d_i,
  input  logic [NPORTS-1:0] cond_q_i,
  input  logic [NPORTS-1:0] trn_en_i,
  input  logic              rd_i,
  output dti_flags_t        flags_o,
  output logic              int_n_o
);
  logic [NPORTS-1:0] chg, pend_d, pend_q;
  logic              trn_d, trn_q, irq_q, int_n_q;

  always_comb begin
    chg    = cond_d_i ^ cond_q_i;
    // A read clears old events; a change on the same edge is kept.
    pend_d = (rd_i ? '0 : pend_q) | (chg & trn_en_i);
    trn_d  = (trn_q & ~rd_i) | (|chg);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= '0;
      trn_q   <= 1'b0;
      irq_q   <= 1'b0;
      int_n_q <= 1'b1;
    end else begin
      pend_q  <= pend_d;
      trn_q   <= trn_d;
      irq_q   <= |pend_d;
      int_n_q <= ~(|pend_d);
    end
  end

  assign flags_o.trn = trn_q;
  assign flags_o.irq = irq_q;
  assign int_n_o     = int_n_q;
endmodule

// File: rtl/dti_input_cond.sv
module dti_input_cond
  import dti_pkg::*;
#(
  parameter int NPORTS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NPORTS-1:0] pin_i,
  input  logic [NPORTS-1:0] deb_en_i,
  input  logic [NPORTS-1:0] trn_en_i,
  input  logic              tick_i,
  input  logic              rd_strobe_i,
  output logic [NPORTS-1:0] cond_o,
  output logic              trn_flag_o,
  output logic              irq_flag_o,
  output logic              int_n_o
);
  logic [NPORTS-1:0] cond_d, cond_q;
  dti_flags_t        flags;

  for (genvar g = 0; g < NPORTS; g++) begin : g_port
    dti_debounce u_deb (
      .clk      (clk),
      .rst      (rst),
      .pin_i    (pin_i[g]),
      .deb_en_i (deb_en_i[g]),
      .tick_i   (tick_i),
      .cond_d_o (cond_d[g]),
      .cond_q_o (cond_q[g])
    );
  end

  dti_event_merge #(.NPORTS(NPORTS)) u_merge (
    .clk      (clk),
    .rst      (rst),
    .cond_d_i (cond_d),
    .cond_q_i (cond_q),
    .trn_en_i (trn_en_i),
    .rd_i     (rd_strobe_i),
    .flags_o  (flags),
    .int_n_o  (int_n_o)
  );

  assign cond_o     = cond_q;
  assign trn_flag_o = flags.trn;
  assign irq_flag_o = flags.irq;
endmodule

// File: rtl/dti_input_cond_chk.sv
module dti_input_cond_chk #(
  parameter int NPORTS = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [NPORTS-1:0] deb_en_i,
  input logic [NPORTS-1:0] trn_en_i,
  input logic              tick_i,
  input logic              rd_strobe_i,
  input logic [NPORTS-1:0] cond_o,
  input logic              trn_flag_o,
  input logic              irq_flag_o,
  input logic              int_n_o
);
  // R3: debounced ports hold without a tick
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !tick_i |=> (((cond_o ^ $past(cond_o)) & $past(deb_en_i)) == '0));

  // R5: any conditioned change sets the change flag
  p_trn_set_r5: assert property (@(posedge clk) disable iff (rst)
    (cond_o != $past(cond_o)) |-> trn_flag_o);

  // R6: an enabled change sets interrupt status
  p_irq_set_r6: assert property (@(posedge clk) disable iff (rst)
    (((cond_o ^ $past(cond_o)) & $past(trn_en_i)) != '0) |-> irq_flag_o);

  // R7: pin mirrors status, active low
  p_pin_match_r7: assert property (@(posedge clk) disable iff (rst)
    int_n_o == !irq_flag_o);

  // R8: a read with no concurrent change clears everything
  p_rd_clear_r8: assert property (@(posedge clk) disable iff (rst)
    rd_strobe_i |=> ($stable(cond_o) -> (!trn_flag_o && !irq_flag_o && int_n_o)));
endmodule

bind dti_input_cond dti_input_cond_chk #(.NPORTS(NPORTS)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .deb_en_i    (deb_en_i),
  .trn_en_i    (trn_en_i),
  .tick_i      (tick_i),
  .rd_strobe_i (rd_strobe_i),
  .cond_o      (cond_o),
  .trn_flag_o  (trn_flag_o),
  .irq_flag_o  (irq_flag_o),
  .int_n_o     (int_n_o)
);

// File: tb/dti_input_cond_tb.sv
module dti_input_cond_tb;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] pin = '0, deb = '0, ten = '0;
  logic         tick = 1'b0, rd = 1'b0;
  logic [N-1:0] cond;
  logic         trn, irq, int_n;

  always #4 clk = ~clk;

  dti_input_cond #(.NPORTS(N)) u_dut (
    .clk(clk), .rst(rst), .pin_i(pin), .deb_en_i(deb), .trn_en_i(ten),
    .tick_i(tick), .rd_strobe_i(rd), .cond_o(cond), .trn_flag_o(trn),
    .irq_flag_o(irq), .int_n_o(int_n)
  );

  typedef struct {
    logic [N-1:0] cond;
    logic         trn;
    logic         irq;
    string        tag;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0, failures = 0;
  bit   done = 1'b0;

  // Requirement model state
  logic [N-1:0] m_cond = '0, m_samp = '0;
  logic         m_trn = 1'b0, m_irq = 1'b0;

  task automatic step(input logic [N-1:0] p, input logic [N-1:0] d, input logic [N-1:0] t,
                      input logic tk, input logic r, input string tag);
    logic [N-1:0] nc;
    logic [N-1:0] chg;
    exp_t e;
    @(negedge clk);
    pin = p; deb = d; ten = t; tick = tk; rd = r;
    nc = m_cond;
    for (int i = 0; i < N; i++) begin
      if (!d[i]) nc[i] = p[i];
      else if (tk && (p[i] == m_samp[i])) nc[i] = p[i];
      if (tk) m_samp[i] = p[i];
    end
    chg    = nc ^ m_cond;
    m_trn  = (m_trn & ~r) | (|chg);
    m_irq  = (m_irq & ~r) | (|(chg & t));
    m_cond = nc;
    e.cond = m_cond; e.trn = m_trn; e.irq = m_irq; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // Monitor: compare after each edge
  always @(posedge clk) begin
    #1;
    if (!rst && exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      checks++;
      if (cond !== e.cond || trn !== e.trn || irq !== e.irq || int_n !== !e.irq) begin
        failures++;
        $display("FAIL %s: cond=%h trn=%b irq=%b int_n=%b expected cond=%h trn=%b irq=%b int_n=%b",
                 e.tag, cond, trn, irq, int_n, e.cond, e.trn, e.irq, !e.irq);
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (cond !== '0 || trn !== 1'b0 || irq !== 1'b0 || int_n !== 1'b1) begin
      failures++;
      $display("FAIL R1 reset: cond=%h trn=%b irq=%b int_n=%b expected 00 0 0 1", cond, trn, irq, int_n);
    end
    rst = 1'b0;
    step('0, '0, '0, 0, 0, "R1 idle after reset");
    // R2/R6/R7: pass-through port 0 with change enable
    step(8'h01, '0, 8'h01, 0, 0, "R2 R6 R7 passthrough rise");
    step(8'h01, '0, 8'h01, 0, 0, "R5 sticky hold");
    step(8'h01, '0, 8'h01, 0, 1, "R8 read clears");
    // R6: change on port 1 with enable off
    step(8'h03, '0, 8'h01, 0, 0, "R6 disabled port sets only change flag");
    step(8'h03, '0, 8'h01, 0, 1, "R8 read clears again");
    // R3: debounced port 2
    step(8'h07, 8'h04, 8'h05, 0, 0, "R3 no tick no change");
    step(8'h07, 8'h04, 8'h05, 1, 0, "R3 first tick sample only");
    step(8'h07, 8'h04, 8'h05, 0, 0, "R3 hold between ticks");
    step(8'h07, 8'h04, 8'h05, 1, 0, "R3 second agreeing tick");
    step(8'h07, 8'h04, 8'h05, 0, 1, "R8 read");
    // R4/R9: glitch seen by no tick, then by one tick only
    step(8'h03, 8'h04, 8'h05, 0, 0, "R4 R9 low between ticks");
    step(8'h07, 8'h04, 8'h05, 0, 0, "R4 back high");
    step(8'h03, 8'h04, 8'h05, 1, 0, "R4 R9 low seen by one tick");
    step(8'h07, 8'h04, 8'h05, 1, 0, "R4 R9 disagreeing tick ignored");
    step(8'h07, 8'h04, 8'h05, 1, 0, "R4 stays high");
    // R8: read on same edge as a new change keeps it
    step(8'h06, 8'h04, 8'h05, 0, 1, "R8 change on read edge kept");
    step(8'h06, 8'h04, 8'h05, 0, 0, "R8 kept event holds");
    step(8'h06, 8'h04, 8'h05, 0, 1, "R8 final clear");
    // R3: debounced fall needs two low ticks
    step(8'h02, 8'h04, 8'h00, 1, 0, "R3 first low tick");
    step(8'h02, 8'h04, 8'h00, 1, 0, "R3 R6 confirmed fall, enable off");
    step(8'h02, 8'h04, 8'h00, 0, 0, "R5 sticky after fall");
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule